// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block resolves an address-translation miss. A lookup buffer hands it a virtual page number and an access type. The walker then reads a forward-mapped page table held in memory, one level at a time, starting from a root table. At each level a slice of the virtual page number selects an entry in the current table. The slices are taken from the most significant end downward. The entry that is read supplies the page number of the table at the next level. The entry at the last level supplies the physical page number and the protection field.

A walk ends early with a fault if the entry read at any level is not valid. On a successful walk, the walker updates the leaf entry's usage bits. It always marks the page as referenced, and it marks it as modified for a write access. The updated entry is written back to memory only when one of those bits actually changes. Each walk ends with a single-cycle response that carries either the physical page number or a fault indication together with the level at which the walk stopped.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: A request is accepted only in a cycle where `req_ready` is 1. `req_ready` stays 0 from acceptance until the response has been given. A `req_valid` asserted while the walker is busy has no effect on the walk in progress or on its response.
- R3: Reads go to word address {table page number, index}, with the index in the low IDX_W bits. Level 0 uses `root_ppn` as sampled at acceptance. The index for level l is bits [(LEVELS-1-l)*IDX_W +: IDX_W] of the virtual page number, so the most significant field is used first.
- R4: An entry has this format: bit 0 valid, bit 1 referenced, bit 2 modified, bits 4:3 protection, and bits PPN_W+4:5 page number. The page number of a valid non-leaf entry is the table page number used at the next level.
- R5: An entry whose valid bit is 0, at any level, ends the walk. The response then has `rsp_fault`=1, `rsp_level` equal to that level and `rsp_ppn`=0. No further read and no write is issued.
- R6: A walk in which all LEVELS entries are valid responds with `rsp_fault`=0, `rsp_level`=LEVELS-1, and the leaf's page number and protection field.
- R7: On a successful walk the leaf entry is written back to its own address with the referenced bit set, and with the modified bit also set when `req_write` was 1. All other bits are unchanged.
- R8: The write-back is issued only if it changes the leaf entry. If it would not change the entry, the walk issues no write.
- R9: A memory request that is not yet accepted keeps `mem_req_valid`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_req_ready` is 1.
- R10: Each accepted request produces exactly one response: `rsp_valid` is high for one cycle, and the walker is idle in the cycle after it.
- R11: A successful walk issues exactly LEVELS reads. A walk that faults at level l issues l+1 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request can be accepted |
| req_vpn | input | LEVELS*IDX_W | Virtual page number to translate |
| req_write | input | 1 | Access is a write |
| root_ppn | input | PPN_W | Page number of the root table |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Walk hit a non-valid entry |
| rsp_level | output | $clog2(LEVELS) | Level at which the walk ended |
| rsp_ppn | output | PPN_W | Translated physical page number, 0 on fault |
| rsp_prot | output | 2 | Protection field of the leaf |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | PPN_W+IDX_W | Word address |
| mem_wdata | output | PPN_W+5 | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rdata | input | PPN_W+5 | Read data |

## Verification
The assertions check, on every cycle, the handshake properties: request stability under back-pressure, the single-cycle response followed by idle, the absence of memory traffic while idle, a zero page number on faults, and a leaf level on success. They also check that every write carries the valid and referenced bits and is followed by the response. Only the bench scenarios can show that the walk follows the right chain of tables and picks the right index slice at each level. The same holds for the fault level, the read count per walk, and whether a write-back was needed. The bench compares all of these against its own walk of the memory image over every virtual page number, for reads and writes alike, with stalls on the memory side.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 4,
  parameter int PPN_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [LEVELS*IDX_W-1:0]   req_vpn,
  input  logic                      req_write,
  input  logic [PPN_W-1:0]          root_ppn,
  output logic                      rsp_valid,
  output logic                      rsp_fault,
  output logic [$clog2(LEVELS)-1:0] rsp_level,
  output logic [PPN_W-1:0]          rsp_ppn,
  output logic [1:0]                rsp_prot,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic                      mem_we,
  output logic [PPN_W+IDX_W-1:0]    mem_addr,
  output logic [PPN_W+4:0]          mem_wdata,
  input  logic                      mem_rsp_valid,
  input  logic [PPN_W+4:0]          mem_rdata
);
  localparam int VPN_W = LEVELS * IDX_W;
  localparam int LVL_W = $clog2(LEVELS);
  localparam int DW    = PPN_W + 5;
  localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WAIT, S_WB, S_RESP} st_t;

  st_t               st;
  logic [LVL_W-1:0]  lvl;
  logic [VPN_W-1:0]  vpn_q;
  logic              wr_q;
  logic [PPN_W-1:0]  base_q;
  logic [DW-1:0]     pte_q;
  logic              fault_q;
  logic [VPN_W-1:0]  vpn_sh;
  logic [DW-1:0]     upd;

  assign vpn_sh = vpn_q >> (IDX_W * (LEVELS - 1 - int'(lvl)));
  assign upd    = mem_rdata | DW'({wr_q, 1'b1, 1'b0});

  assign req_ready     = (st == S_IDLE);
  assign rsp_valid     = (st == S_RESP);
  assign rsp_fault     = fault_q;
  assign rsp_level     = lvl;
  assign rsp_ppn       = pte_q[DW-1:5];
  assign rsp_prot      = pte_q[4:3];
  assign mem_req_valid = (st == S_READ) || (st == S_WB);
  assign mem_we        = (st == S_WB);
  assign mem_addr      = {base_q, vpn_sh[IDX_W-1:0]};
  assign mem_wdata     = pte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lvl     <= '0;
      vpn_q   <= '0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      pte_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          vpn_q   <= req_vpn;
          wr_q    <= req_write;
          base_q  <= root_ppn;
          lvl     <= '0;
          fault_q <= 1'b0;
          pte_q   <= '0;
          st      <= S_READ;
        end
        S_READ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!mem_rdata[0]) begin
            fault_q <= 1'b1;
            pte_q   <= '0;
            st      <= S_RESP;
          end else if (lvl == LAST) begin
            pte_q <= upd;
            st    <= (upd != mem_rdata) ? S_WB : S_RESP;
          end else begin
            base_q <= mem_rdata[DW-1:5];
            lvl    <= lvl + 1'b1;
            st     <= S_READ;
          end
        end
        S_WB:   if (mem_req_ready) st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pt_walker_chk #(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 4,
  parameter int PPN_W  = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_ready,
  input logic                      rsp_valid,
  input logic                      rsp_fault,
  input logic [$clog2(LEVELS)-1:0] rsp_level,
  input logic [PPN_W-1:0]          rsp_ppn,
  input logic                      mem_req_valid,
  input logic                      mem_req_ready,
  input logic                      mem_we,
  input logic [PPN_W+IDX_W-1:0]    mem_addr,
  input logic [PPN_W+4:0]          mem_wdata
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_we)
      && $stable(mem_addr) && $stable(mem_wdata));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !rsp_valid);

  assert_fault_ppn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_ppn == '0);

  assert_leaf_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> int'(rsp_level) == LEVELS - 1);

  assert_wb_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we |-> mem_wdata[0] && mem_wdata[1]);

  assert_wb_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we && mem_req_ready |=> rsp_valid && !rsp_fault);
endmodule

bind pt_walker pt_walker_chk #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_chk (.*);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 3;
  localparam int IW = 2;
  localparam int PW = 4;
  localparam int VW = L * IW;
  localparam int AW = PW + IW;
  localparam int DW = PW + 5;
  localparam int LW = $clog2(L);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [VW-1:0] req_vpn = '0;
  logic [PW-1:0] root_ppn = '0;
  logic req_ready, rsp_valid, rsp_fault, mem_req_valid, mem_we;
  logic [LW-1:0] rsp_level;
  logic [PW-1:0] rsp_ppn;
  logic [1:0] rsp_prot;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_req_ready, mem_rsp_valid;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker #(.LEVELS(L), .IDX_W(IW), .PPN_W(PW)) u0 (.*);

  logic [DW-1:0] mem [1<<AW];
  logic [7:0] lf;
  logic pend;
  logic [AW-1:0] paddr, lwa;
  logic [DW-1:0] lwd;
  int rcnt, wcnt;

  assign mem_req_ready = lf[0] | lf[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      lf <= 8'hA5; pend <= 1'b0; mem_rsp_valid <= 1'b0; mem_rdata <= '0;
      rcnt <= 0; wcnt <= 0; paddr <= '0; lwa <= '0; lwd <= '0;
    end else begin
      lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mem_rsp_valid <= 1'b0;
      if (pend) begin
        mem_rsp_valid <= 1'b1;
        mem_rdata <= mem[paddr];
        pend <= 1'b0;
      end
      if (mem_req_valid && mem_req_ready) begin
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata; wcnt <= wcnt + 1;
          lwa <= mem_addr; lwd <= mem_wdata;
        end else begin
          pend <= 1'b1; paddr <= mem_addr; rcnt <= rcnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ent(int ppn, int prot, bit d, bit r, bit v);
    return {PW'(ppn), 2'(prot), d, r, v};
  endfunction

  task automatic walk(input int vpn, input bit wr, input bit junk);
    int base, lv, sr, sw, n;
    bit efault;
    logic [DW-1:0] e, leaf_new;
    logic [AW-1:0] la;
    int eppn, eprot, elvl, ereads;
    bit ewrite;
    base = 1; efault = 0; elvl = 0; e = '0; la = '0;
    for (int l = 0; l < L; l++) begin
      la = {PW'(base), IW'(vpn >> (IW * (L - 1 - l)))};
      e = mem[la];
      elvl = l;
      if (!e[0]) begin efault = 1; break; end
      base = int'(e[DW-1:5]);
    end
    leaf_new = e | DW'({wr, 2'b10});
    ereads = elvl + 1;
    ewrite = !efault && (leaf_new != e);
    eppn = efault ? 0 : int'(e[DW-1:5]);
    eprot = efault ? 0 : int'(e[4:3]);
    sr = rcnt; sw = wcnt;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = VW'(vpn); req_write = wr; root_ppn = 4'd1;
    @(negedge clk);
    chk(!req_ready, "R2 busy after accept", req_ready, 0);
    root_ppn = 4'd0;
    if (junk) begin req_vpn = ~VW'(vpn); req_write = ~wr; end
    else req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin
      if (junk) chk(!req_ready, "R2 ignored while busy", req_ready, 0);
      @(negedge clk); n++;
    end
    req_valid = 1'b0;
    chk(rsp_valid, "R10 response arrives", rsp_valid, 1);
    chk(rsp_fault == efault, "R5 fault flag", rsp_fault, efault);
    chk(int'(rsp_level) == elvl, efault ? "R5 fault level" : "R6 leaf level", rsp_level, elvl);
    chk(int'(rsp_ppn) == eppn, efault ? "R5 ppn zero" : "R4 R6 ppn", rsp_ppn, eppn);
    if (!efault) chk(int'(rsp_prot) == eprot, "R6 prot", rsp_prot, eprot);
    chk(rcnt - sr == ereads, "R3 R11 read count", rcnt - sr, ereads);
    chk(wcnt - sw == int'(ewrite), "R7 R8 write count", wcnt - sw, ewrite);
    if (ewrite) begin
      chk(lwa == la, "R7 write address", lwa, la);
      chk(lwd == leaf_new, "R7 write data", lwd, leaf_new);
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10 single pulse then idle", rsp_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad + 1);
    $finish;
  end

  initial begin
    for (int a = 0; a < (1 << AW); a++) mem[a] = '0;
    mem[{4'd1, 2'd0}] = ent(2, 0, 0, 0, 1);
    mem[{4'd1, 2'd1}] = ent(3, 0, 0, 0, 1);
    mem[{4'd1, 2'd3}] = ent(2, 1, 0, 0, 1);
    for (int j = 0; j < 3; j++) mem[{4'd2, 2'(j)}] = ent(4 + j, 0, 0, 0, 1);
    for (int j = 0; j < 4; j++) mem[{4'd3, 2'(j)}] = ent(8 + j, 0, 0, 0, 1);
    for (int t = 4; t < 12; t++)
      for (int k = 0; k < 4; k++)
        mem[{4'(t), 2'(k)}] = ent((t * 3 + k) & 15, (t ^ k) & 3, k == 3,
                                  k == 1 || k == 3, !(k == 2 && t[0]));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(!rsp_valid, "R1 no response after reset", rsp_valid, 0);
    chk(!mem_req_valid, "R1 no memory request after reset", mem_req_valid, 0);
    for (int pass = 0; pass < 3; pass++)
      for (int v = 0; v < (1 << VW); v++)
        walk(v, pass == 1, v[0]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule